// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between an out-of-order issue stage and the architectural register state. Every instruction that issues claims one slot at the tail of a circular queue. The slot records the register it will write, or no register for a store, plus the tag of the reservation station that will produce its result, and whether it is a branch. Issue order is also the queue order.

Results arrive out of order on a common data bus as a tag and a value. The slot holding a matching tag takes the value and is marked finished. Retirement happens only at the head of the queue, at most one slot per cycle. A finished head slot that names a register copies its value into a commit-side register file, so the final value of any register follows program order.

Branches are assumed not taken at issue. A branch result on the bus carries a mispredict flag. When a branch with that flag set retires, every younger slot is discarded. In the same cycle a restore pulse tells the issue side to reload its register view from the commit-side file, which is exposed on a flat output bus.

Top module: `rob_inorder`

## Requirements
- R1: A slot is claimed when `issueValid` and `issueReady` are both high at a clock edge, and slots retire in the order they were claimed.
- R2: A slot records whether it writes a register (`issueHasDst`), which register (`issueDst`), and its producer tag. At retirement `commitHasDst` and `commitDst` reproduce these fields.
- R3: A bus broadcast (`cdbValid`) completes only a valid slot that is not yet finished and has an equal tag, and stores `cdbValue` in it. A broadcast whose tag matches no such slot has no effect.
- R4: `commitValid` is high for one cycle per retired slot. It appears only when the head slot is finished, the cycle after its broadcast edge. A finished slot behind an unfinished head waits.
- R5: When a retiring slot has a destination, `archFile` bits `[r*DATA_W +: DATA_W]` take `commitValue` at that edge. Retiring a slot without a destination leaves `archFile` unchanged.
- R6: With DEPTH (8) slots occupied, `issueReady` is low and an issue request is ignored.
- R7: Retiring a branch whose broadcast carried `cdbMispredict`=1 raises `restorePulse` for that single cycle. All younger slots are discarded, so their later broadcasts produce no retirement. `archFile` holds exactly the results that retired before the branch, and issue resumes the next cycle.
- R8: A branch that retires with its mispredict flag clear, or a non-branch slot whose broadcast had `cdbMispredict`=1, retires without `restorePulse`.
- R9: After reset, `issueReady`=1, `commitValid`=0, `restorePulse`=0 and `archFile` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueReady | output | 1 | A slot can be claimed this cycle |
| issueHasDst | input | 1 | Instruction writes a register |
| issueDst | input | 2 | Destination register index |
| issueTag | input | 4 | Producer station tag |
| issueIsBranch | input | 1 | Instruction is a branch predicted not taken |
| cdbValid | input | 1 | Result broadcast valid |
| cdbTag | input | 4 | Broadcast tag |
| cdbValue | input | 32 | Broadcast value |
| cdbMispredict | input | 1 | Branch outcome differs from prediction |
| commitValid | output | 1 | Head slot retires this cycle |
| commitHasDst | output | 1 | Retiring slot writes a register |
| commitDst | output | 2 | Retiring slot destination |
| commitValue | output | 32 | Retiring slot value |
| restorePulse | output | 1 | Flush and reload issue-side registers |
| archFile | output | 128 | Commit-side register file, register r at bits r*32 |

## Verification
The bench broadcasts results in reverse issue order. A buffer that retired finished slots without waiting for the head would then emit commits out of sequence, and two writes to one register would leave the older value. It repeats a tag that has already finished and sends a tag that is not in flight; a match that ignored the finished bit would overwrite a stored result. It fills all eight slots and issues once more, which an off-by-one full test would accept as a ninth slot. It retires a mispredicted branch with finished younger slots behind it and then reuses a flushed tag. A buffer that kept stale slots or mis-set its pointers would retire discarded work or lose the new instruction.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Control-to-datapath strobes issued once per cycle
  typedef struct packed {
    logic alloc;   // write a new slot at the tail
    logic retire;  // release the head slot
    logic flush;   // discard every slot
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             headReady,
  input  logic             headFlushReq,
  output robStrobe_t       strobe,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [CNT_W-1:0] entryCount,
  output logic             issueReady
);

  logic full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full          = (entryCount == CNT_W'(DEPTH));
    strobe.retire = headReady;
    strobe.flush  = headReady && headFlushReq;
    issueReady    = !full && !strobe.flush;
    strobe.alloc  = issueValid && issueReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr    <= '0;
      tailPtr    <= '0;
      entryCount <= '0;
    end else if (strobe.flush) begin
      headPtr    <= '0;
      tailPtr    <= '0;
      entryCount <= '0;
    end else begin
      if (strobe.retire) headPtr <= bump(headPtr);
      if (strobe.alloc)  tailPtr <= bump(tailPtr);
      entryCount <= entryCount + CNT_W'(strobe.alloc) - CNT_W'(strobe.retire);
    end
  end

endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREG   = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  robStrobe_t             strobe,
  input  logic [PTR_W-1:0]       headPtr,
  input  logic [PTR_W-1:0]       tailPtr,
  input  logic                   issueHasDst,
  input  logic [REG_W-1:0]       issueDst,
  input  logic [TAG_W-1:0]       issueTag,
  input  logic                   issueIsBranch,
  input  logic                   cdbValid,
  input  logic [TAG_W-1:0]       cdbTag,
  input  logic [DATA_W-1:0]      cdbValue,
  input  logic                   cdbMispredict,
  output logic                   headReady,
  output logic                   headFlushReq,
  output logic                   commitHasDst,
  output logic [REG_W-1:0]       commitDst,
  output logic [DATA_W-1:0]      commitValue,
  output logic [NREG*DATA_W-1:0] archFile
);

  logic              entValid  [DEPTH];
  logic              entDone   [DEPTH];
  logic              entHasDst [DEPTH];
  logic              entBranch [DEPTH];
  logic              entMiss   [DEPTH];
  logic [REG_W-1:0]  entDst    [DEPTH];
  logic [TAG_W-1:0]  entTag    [DEPTH];
  logic [DATA_W-1:0] entValue  [DEPTH];
  logic [DEPTH-1:0]  wbHit;

  logic [DATA_W-1:0] archReg [NREG];

  // Tag match per slot: only live, unfinished slots accept a result
  for (genvar i = 0; i < DEPTH; i++) begin : gMatch
    assign wbHit[i] = cdbValid && entValid[i] && !entDone[i] && (entTag[i] == cdbTag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.flush) begin
          entValid[i] <= 1'b0;
          entDone[i]  <= 1'b0;
        end else begin
          if (strobe.alloc && tailPtr == PTR_W'(i)) begin
            entValid[i]  <= 1'b1;
            entDone[i]   <= 1'b0;
            entHasDst[i] <= issueHasDst;
            entDst[i]    <= issueDst;
            entTag[i]    <= issueTag;
            entBranch[i] <= issueIsBranch;
            entMiss[i]   <= 1'b0;
          end else if (strobe.retire && headPtr == PTR_W'(i)) begin
            entValid[i] <= 1'b0;
          end
          if (wbHit[i]) begin
            entDone[i]  <= 1'b1;
            entValue[i] <= cdbValue;
            entMiss[i]  <= cdbMispredict;
          end
        end
      end
    end
  end

  always_comb begin
    headReady    = entValid[headPtr] && entDone[headPtr];
    headFlushReq = entBranch[headPtr] && entMiss[headPtr];
    commitHasDst = entHasDst[headPtr];
    commitDst    = entDst[headPtr];
    commitValue  = entValue[headPtr];
  end

  // Commit-side register file, written only at retirement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) archReg[r] <= '0;
    end else if (strobe.retire && commitHasDst) begin
      archReg[commitDst] <= commitValue;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : gFlat
    assign archFile[r*DATA_W +: DATA_W] = archReg[r];
  end

endmodule

// File: rtl/rob_inorder.sv
module rob_inorder
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREG   = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   issueValid,
  output logic                   issueReady,
  input  logic                   issueHasDst,
  input  logic [REG_W-1:0]       issueDst,
  input  logic [TAG_W-1:0]       issueTag,
  input  logic                   issueIsBranch,
  input  logic                   cdbValid,
  input  logic [TAG_W-1:0]       cdbTag,
  input  logic [DATA_W-1:0]      cdbValue,
  input  logic                   cdbMispredict,
  output logic                   commitValid,
  output logic                   commitHasDst,
  output logic [REG_W-1:0]       commitDst,
  output logic [DATA_W-1:0]      commitValue,
  output logic                   restorePulse,
  output logic [NREG*DATA_W-1:0] archFile
);

  robStrobe_t       strobe;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [CNT_W-1:0] entryCount;
  logic             headReady;
  logic             headFlushReq;

  rob_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .issueValid   (issueValid),
    .headReady    (headReady),
    .headFlushReq (headFlushReq),
    .strobe       (strobe),
    .headPtr      (headPtr),
    .tailPtr      (tailPtr),
    .entryCount   (entryCount),
    .issueReady   (issueReady)
  );

  rob_store #(
    .DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) store (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .headPtr       (headPtr),
    .tailPtr       (tailPtr),
    .issueHasDst   (issueHasDst),
    .issueDst      (issueDst),
    .issueTag      (issueTag),
    .issueIsBranch (issueIsBranch),
    .cdbValid      (cdbValid),
    .cdbTag        (cdbTag),
    .cdbValue      (cdbValue),
    .cdbMispredict (cdbMispredict),
    .headReady     (headReady),
    .headFlushReq  (headFlushReq),
    .commitHasDst  (commitHasDst),
    .commitDst     (commitDst),
    .commitValue   (commitValue),
    .archFile      (archFile)
  );

  assign commitValid  = strobe.retire;
  assign restorePulse = strobe.flush;

endmodule

// File: rtl/rob_inorder_chk.sv
module rob_inorder_chk #(
  parameter int DEPTH  = 8,
  parameter int NREG   = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   issueReady,
  input logic                   commitValid,
  input logic                   commitHasDst,
  input logic                   restorePulse,
  input logic [NREG*DATA_W-1:0] archFile,
  input logic [CNT_W-1:0]       entryCount
);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= CNT_W'(DEPTH));

  assert_full_blocks_issue_R6: assert property (@(posedge clk) disable iff (!rstN)
    (entryCount == CNT_W'(DEPTH)) |-> !issueReady);

  assert_commit_has_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (entryCount != '0));

  assert_restore_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    restorePulse |=> (entryCount == '0));

  assert_restore_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    restorePulse |=> !restorePulse);

  assert_arch_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(commitValid && commitHasDst) |=> $stable(archFile));

endmodule

bind rob_inorder rob_inorder_chk #(
  .DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W)
) chkInst (
  .clk          (clk),
  .rstN         (rstN),
  .issueReady   (issueReady),
  .commitValid  (commitValid),
  .commitHasDst (commitHasDst),
  .restorePulse (restorePulse),
  .archFile     (archFile),
  .entryCount   (entryCount)
);

// File: tb/rob_inorder_test.sv
module rob_inorder_test;

  localparam int DEPTH  = 8;
  localparam int NREG   = 4;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;

  typedef struct {
    bit        hasDst;
    bit [1:0]  dst;
    bit [31:0] value;
    bit        chkVal;
    bit        restore;
  } expItem_t;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   issueValid = 1'b0;
  logic                   issueReady;
  logic                   issueHasDst = 1'b0;
  logic [1:0]             issueDst = '0;
  logic [TAG_W-1:0]       issueTag = '0;
  logic                   issueIsBranch = 1'b0;
  logic                   cdbValid = 1'b0;
  logic [TAG_W-1:0]       cdbTag = '0;
  logic [DATA_W-1:0]      cdbValue = '0;
  logic                   cdbMispredict = 1'b0;
  logic                   commitValid;
  logic                   commitHasDst;
  logic [1:0]             commitDst;
  logic [DATA_W-1:0]      commitValue;
  logic                   restorePulse;
  logic [NREG*DATA_W-1:0] archFile;

  expItem_t expQ[$];
  int  total = 0;
  int  fails = 0;
  bit  running = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  rob_inorder #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueReady(issueReady),
    .issueHasDst(issueHasDst), .issueDst(issueDst), .issueTag(issueTag),
    .issueIsBranch(issueIsBranch),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue),
    .cdbMispredict(cdbMispredict),
    .commitValid(commitValid), .commitHasDst(commitHasDst),
    .commitDst(commitDst), .commitValue(commitValue),
    .restorePulse(restorePulse), .archFile(archFile)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] archOf(input int r);
    return archFile[r*DATA_W +: DATA_W];
  endfunction

  // Driver: one issue per cycle; push expectation when the slot should retire
  task automatic doIssue(input bit hasDst, input bit [1:0] dst, input bit [3:0] tag,
                         input bit isBr, input bit [31:0] val, input bit push, input bit restore);
    expItem_t it;
    @(negedge clk);
    issueValid    = 1'b1;
    issueHasDst   = hasDst;
    issueDst      = dst;
    issueTag      = tag;
    issueIsBranch = isBr;
    @(posedge clk);
    #1 issueValid = 1'b0;
    if (push) begin
      it.hasDst  = hasDst;
      it.dst     = dst;
      it.value   = val;
      it.chkVal  = !isBr;
      it.restore = restore;
      expQ.push_back(it);
    end
  endtask

  task automatic doCast(input bit [3:0] tag, input bit [31:0] val, input bit miss);
    @(negedge clk);
    cdbValid      = 1'b1;
    cdbTag        = tag;
    cdbValue      = val;
    cdbMispredict = miss;
    @(posedge clk);
    #1 cdbValid = 1'b0;
    cdbMispredict = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (expQ.size() != 0 && n < 200) begin
      @(posedge clk);
      n++;
    end
    repeat (4) @(posedge clk);
    check(expQ.size() == 0, "R4 pending retirements", expQ.size(), 0);
  endtask

  // Monitor: compare every retirement with the head of the scoreboard
  always @(negedge clk) begin
    #2;
    if (running && rstN) begin
      if (commitValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 R4 unexpected retirement", commitValue, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(commitHasDst == it.hasDst, "R2 commitHasDst", commitHasDst, it.hasDst);
          if (it.hasDst)
            check(commitDst == it.dst, "R2 commitDst", commitDst, it.dst);
          if (it.chkVal)
            check(commitValue == it.value, "R3 R1 commitValue order", commitValue, it.value);
          check(restorePulse == it.restore, "R7 R8 restorePulse", restorePulse, it.restore);
        end
      end else if (restorePulse) begin
        check(1'b0, "R7 restore without retirement", 1, 0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    #2;
    // R9 reset state
    check(issueReady == 1'b1, "R9 issueReady", issueReady, 1);
    check(commitValid == 1'b0, "R9 commitValid", commitValid, 0);
    check(restorePulse == 1'b0, "R9 restorePulse", restorePulse, 0);
    check(archFile == '0, "R9 archFile", archFile[31:0], 0);
    running = 1'b1;

    // R1 R4 R5: results return in reverse order; two writes to r0
    doIssue(1, 0, 1, 0, 32'h11, 1, 0);
    doIssue(0, 0, 2, 0, 32'h22, 1, 0);   // store, no destination
    doIssue(1, 0, 3, 0, 32'h33, 1, 0);
    doIssue(1, 1, 4, 0, 32'h44, 1, 0);
    doCast(4, 32'h44, 0);
    doCast(3, 32'h33, 0);
    doCast(2, 32'h22, 0);
    repeat (2) @(posedge clk);
    check(commitValid == 1'b0, "R4 head waits", commitValid, 0);
    doCast(1, 32'h11, 0);
    drain();
    check(archOf(0) == 32'h33, "R5 last write to r0 wins", archOf(0), 32'h33);
    check(archOf(1) == 32'h44, "R5 r1 value", archOf(1), 32'h44);
    check(archOf(2) == 32'h0, "R5 store leaves r2", archOf(2), 0);

    // R3: duplicate and unknown tags ignored
    doIssue(1, 2, 5, 0, 32'h55, 1, 0);
    doIssue(1, 3, 6, 0, 32'h66, 1, 0);
    doCast(6, 32'h66, 0);
    doCast(6, 32'hBAD, 0);
    doCast(9, 32'hBEEF, 0);
    doCast(5, 32'h55, 0);
    drain();
    check(archOf(3) == 32'h66, "R3 finished slot kept value", archOf(3), 32'h66);
    check(archOf(2) == 32'h55, "R3 r2 value", archOf(2), 32'h55);

    // R6: fill all slots, one more request ignored
    for (int i = 0; i < DEPTH; i++)
      doIssue(1, 3, 4'(i), 0, 32'h100 + i, 1, 0);
    @(negedge clk);
    #2;
    check(issueReady == 1'b0, "R6 issueReady when full", issueReady, 0);
    doIssue(1, 2, 8, 0, 32'hF00, 0, 0);
    for (int i = DEPTH - 1; i >= 0; i--)
      doCast(4'(i), 32'h100 + i, 0);
    drain();
    doCast(8, 32'hF00, 0);
    drain();
    check(archOf(3) == 32'h107, "R6 R5 r3 after full run", archOf(3), 32'h107);
    check(archOf(2) == 32'h55, "R6 ignored issue left r2", archOf(2), 32'h55);

    // R7: mispredicted branch with finished younger slots behind it
    doIssue(1, 0, 1, 0, 32'h111, 1, 0);
    doIssue(0, 0, 2, 1, 32'h0, 1, 1);
    doIssue(1, 0, 3, 0, 32'h333, 0, 0);
    doIssue(0, 0, 4, 0, 32'h444, 0, 0);
    doCast(3, 32'h333, 0);
    doCast(4, 32'h444, 0);
    doCast(1, 32'h111, 0);
    doCast(2, 32'h0, 1);
    drain();
    check(archOf(0) == 32'h111, "R7 r0 holds pre-branch value", archOf(0), 32'h111);
    check(issueReady == 1'b1, "R7 issue resumes", issueReady, 1);
    doCast(3, 32'hDEAD, 0);
    drain();
    doIssue(1, 1, 3, 0, 32'h777, 1, 0);
    doCast(3, 32'h777, 0);
    drain();
    check(archOf(1) == 32'h777, "R7 reused tag after flush", archOf(1), 32'h777);

    // R8: correct branch and a stray mispredict flag on a plain result
    doIssue(0, 0, 5, 1, 32'h0, 1, 0);
    doIssue(1, 2, 6, 0, 32'h666, 1, 0);
    doCast(6, 32'h666, 1);
    doCast(5, 32'h0, 0);
    drain();
    check(archOf(2) == 32'h666, "R8 no flush on correct branch", archOf(2), 32'h666);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule